// File: doc/BRIEF.md
# Multi-Lane Serial Audio Receiver

This block takes digital audio in on one shared bit clock and one shared frame clock and hands back a complete frame of twelve 24-bit samples together with a one-cycle valid strobe. It runs in one of two lane layouts. In the first, six data lanes each carry a left and right pair. In the second, one time-division lane carries all twelve channels. For the paired layout it accepts three alignments: an I2S-style one-bit delay, a left-aligned layout and a right-aligned layout.

All inputs pass through synchronisers into the system clock domain, so the bit clock must be several times slower than the system clock. By default the block is a slave to the incoming bit clock. Setting the clock-generate option makes it ignore the bit clock input. It then measures the frame clock period in system clocks and derives its own bit timing from it: 64 bits per frame for the paired layout and 512 bits per frame for the time-division layout. It also drives that generated bit clock out. The configuration inputs are static and may only change while reset is held.

Top module: `sai_rx_port`

## Requirements
- R1: While reset is held and after it is released, `frame_valid` is 0, `samples_out` is all zeros and `bclk_out` is 0.
- R2: With `cfg_fmt` = 2'b00 (I2S style), a low frame clock marks the left word. Each 32-bit half starts at a frame clock change, and the MSB comes one bit after that change. Lane k carries channel 2k (left) and channel 2k+1 (right). Channel c occupies `samples_out[24c+23:24c]`, and the first bit received is the MSB.
- R3: With `cfg_fmt` = 2'b01 (left aligned), a high frame clock marks the left word, and the MSB is in the first bit of each 32-bit half.
- R4: With `cfg_fmt` = 2'b10 (right aligned), a high frame clock marks the left word, and the LSB is in the last (32nd) bit of each half, so the MSB is in bit 8.
- R5: With `cfg_fmt` = 2'b11 (time division), a frame starts at a rising edge of the frame pulse. The frame has 16 slots of 32 bits. Slot s (0 to 11) carries channel s on lane 0, with the MSB in the slot's first bit. Lanes 1 to 5 are ignored.
- R6: `frame_valid` is a single-cycle pulse, issued once per completed frame. `samples_out` changes only in the cycle in which `frame_valid` is high.
- R7: A frame is discarded if a frame clock edge ends it before its last sample word is complete. No pulse is issued, `samples_out` keeps its old value, and the next full frame is captured normally.
- R8: With `cfg_bclk_gen` = 1 in a paired format, the block ignores `bclk_in`. From the second frame edge onward it times bits at the measured frame period divided by 64, and `bclk_out` shows 64 rising edges per frame.
- R9: With `cfg_bclk_gen` = 1 in time-division format, bit timing is the measured frame period divided by 512, and all twelve slots are captured.
- R10: With `cfg_bclk_gen` = 0, `bclk_out` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Format: 00 I2S style, 01 left aligned, 10 right aligned, 11 time division |
| cfg_bclk_gen | input | 1 | 1 = derive the bit clock from the frame clock, 0 = slave to `bclk_in` |
| bclk_in | input | 1 | External bit clock; data is sampled at its rising edges |
| fclk_in | input | 1 | Frame clock (paired formats) or frame pulse (time division) |
| sdata_in | input | 6 | Serial data lanes; lane 0 is the time-division lane |
| bclk_out | output | 1 | Generated bit clock, held low in slave mode |
| samples_out | output | 288 | Twelve 24-bit samples; channel c in bits 24c+23:24c |
| frame_valid | output | 1 | One-cycle pulse when a new frame is on `samples_out` |

## Verification
A wrong bit position counter or a wrong format offset shows up immediately as shifted or byte-swapped sample values in the first captured frame. A wrong left/right decode shows up as swapped channel pairs. A frame that is not discarded when it is cut short shows up as an extra `frame_valid` pulse and a change of `samples_out` before the following full frame. A wrong divider in the generated clock is visible within one frame period: the `bclk_out` edge count is wrong and the captured values are misaligned.

// File: rtl/sai_rx_pkg.sv
// Shared types for the serial audio receiver.
package sai_rx_pkg;
    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_TDM = 2'b11
    } fmt_e;
endpackage

// File: rtl/sai_rx_sync.sv
// Two-stage synchroniser for asynchronous serial inputs.
// Assumes the inputs change slowly relative to clk.
module sai_rx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Resample the asynchronous inputs twice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= din;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sai_rx_bitgen.sv
// Internal bit timing generator. Measures the frame period in system clocks
// between rising frame edges, divides it by the bits per frame and issues a
// mid-bit tick. The bit phase restarts at every rising frame edge.
// Assumes a period of at least 2 system clocks per bit.
module sai_rx_bitgen #(
    parameter int PER_W        = 16,
    parameter int STEREO_SHIFT = 6,
    parameter int TDM_SHIFT    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tdm,
    input  logic frm_rise,
    output logic tick,
    output logic bclk_out
);
    logic [PER_W-1:0] per_cnt, per_meas, tcnt, bit_per, half;
    logic             started, have_per, run;

    always_comb begin
        bit_per = tdm ? (per_meas >> TDM_SHIFT) : (per_meas >> STEREO_SHIFT);
        half    = bit_per >> 1;
        run     = en & have_per & (bit_per >= PER_W'(2));
        tick    = run & (tcnt == half);
    end

    // Measure the frame period between rising frame edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            per_cnt  <= '0;
            per_meas <= '0;
            started  <= 1'b0;
            have_per <= 1'b0;
        end else if (frm_rise) begin
            if (started) begin
                per_meas <= per_cnt + 1'b1;
                have_per <= 1'b1;
            end
            started <= 1'b1;
            per_cnt <= '0;
        end else if (per_cnt != '1) begin
            per_cnt <= per_cnt + 1'b1;
        end
    end

    // Bit phase counter, restarted at each frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || frm_rise) begin
            tcnt <= '0;
        end else if (tcnt >= bit_per - 1'b1) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Generated bit clock: high in the second half of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_out <= 1'b0;
        else        bclk_out <= run & (tcnt >= half);
    end

    AST_LOCK_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(have_per) |-> $past(frm_rise)); // R8
    AST_SLAVE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bclk_out); // R10
endmodule

// File: rtl/sai_rx_deser.sv
// Deserialiser shared by all formats. On each bit tick it tracks the bit
// position since the last frame-clock event, shifts the bits into per-channel
// registers and publishes the frame when its last word completes.
// Assumes tick is a single-cycle strobe, with fs and sd valid alongside it.
module sai_rx_deser
    import sai_rx_pkg::*;
#(
    parameter int LANES     = 6,
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_W    = 32,
    parameter int TDM_SLOTS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      fs,
    input  logic [LANES-1:0]          sd,
    input  fmt_e                      fmt,
    output logic [2*LANES*SAMPLE_W-1:0] samples,
    output logic                      frame_valid
);
    localparam int NCH        = 2 * LANES;
    localparam int POS_W      = $clog2(SLOT_W * TDM_SLOTS);
    localparam int SB_W       = $clog2(SLOT_W);
    localparam int SLOT_IDX_W = POS_W - SB_W;

    logic                  f_prev, side, in_sync, left_done, done_q;
    logic [POS_W-1:0]      pos, pos_nx;
    logic                  is_tdm, evt, side_nx, sync_nx;
    logic [SB_W:0]         msb_off, lsb_pos, bit_pos;
    logic [SLOT_IDX_W-1:0] slot_no;
    logic                  in_word, last, slot_ok, cap, complete;
    logic [NCH-1:0]        shift_en, bit_in;
    logic [SAMPLE_W-1:0]   shreg [NCH];

    // Decode the frame event, bit position and capture window for this tick.
    always_comb begin
        is_tdm  = (fmt == FMT_TDM);
        evt     = is_tdm ? (fs & ~f_prev) : (fs ^ f_prev);
        pos_nx  = evt ? '0 : ((pos == '1) ? pos : pos + 1'b1);
        side_nx = evt ? ((fmt == FMT_I2S) ? fs : ~fs) : side;
        sync_nx = in_sync | evt;
        case (fmt)
            FMT_I2S: msb_off = (SB_W+1)'(1);
            FMT_RJ:  msb_off = (SB_W+1)'(SLOT_W - SAMPLE_W);
            default: msb_off = '0;
        endcase
        lsb_pos  = msb_off + (SB_W+1)'(SAMPLE_W - 1);
        bit_pos  = {1'b0, pos_nx[SB_W-1:0]};
        slot_no  = pos_nx[POS_W-1:SB_W];
        in_word  = (bit_pos >= msb_off) && (bit_pos <= lsb_pos);
        last     = (bit_pos == lsb_pos);
        slot_ok  = is_tdm ? (slot_no < SLOT_IDX_W'(NCH)) : (pos_nx < POS_W'(SLOT_W));
        cap      = tick & sync_nx & in_word & slot_ok;
        complete = cap & last &
                   (is_tdm ? (slot_no == SLOT_IDX_W'(NCH - 1)) : (side_nx & left_done));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign shift_en[c] = cap & (is_tdm ? (slot_no == SLOT_IDX_W'(c))
                                           : (side_nx == 1'(c % 2)));
        assign bit_in[c]   = is_tdm ? sd[0] : sd[c / 2];
    end

    // Track frame position, channel side and left-word completion per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_prev    <= 1'b0;
            pos       <= '1;
            side      <= 1'b0;
            in_sync   <= 1'b0;
            left_done <= 1'b0;
        end else if (tick) begin
            f_prev  <= fs;
            pos     <= pos_nx;
            side    <= side_nx;
            in_sync <= sync_nx;
            if (evt && !side_nx)
                left_done <= 1'b0;
            else if (cap && last && !side_nx && !is_tdm)
                left_done <= 1'b1;
        end
    end

    // Shift the received bits into the channel registers, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) shreg[c] <= '0;
        end else begin
            for (int c = 0; c < NCH; c++)
                if (shift_en[c]) shreg[c] <= {shreg[c][SAMPLE_W-2:0], bit_in[c]};
        end
    end

    // Publish a completed frame one cycle after its last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            frame_valid <= 1'b0;
            samples     <= '0;
        end else begin
            done_q      <= complete;
            frame_valid <= done_q;
            if (done_q)
                for (int c = 0; c < NCH; c++) samples[c*SAMPLE_W +: SAMPLE_W] <= shreg[c];
        end
    end

    AST_TDM_ONE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        is_tdm |-> $onehot0(shift_en)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R6
    AST_HOLD_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(samples)); // R6
    AST_EVT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && evt) |=> (pos == '0)); // R7
endmodule

// File: rtl/sai_rx_port.sv
// Multi-lane serial audio receiver top. Synchronises the serial inputs,
// selects between the external bit clock and the internal bit timing, and
// feeds the shared deserialiser. The configuration must only change in reset.
module sai_rx_port
    import sai_rx_pkg::*;
#(
    parameter int LANES     = 6,
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_W    = 32,
    parameter int TDM_SLOTS = 16,
    parameter int PER_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cfg_fmt,
    input  logic                        cfg_bclk_gen,
    input  logic                        bclk_in,
    input  logic                        fclk_in,
    input  logic [LANES-1:0]            sdata_in,
    output logic                        bclk_out,
    output logic [2*LANES*SAMPLE_W-1:0] samples_out,
    output logic                        frame_valid
);
    localparam int SYNC_W       = LANES + 2;
    localparam int STEREO_SHIFT = $clog2(2 * SLOT_W);
    localparam int TDM_SHIFT    = $clog2(TDM_SLOTS * SLOT_W);

    logic [SYNC_W-1:0] sync_q;
    logic [1:0]        clk_d;
    logic              bclk_rise, frm_rise, gen_tick, tick;
    fmt_e              fmt;

    assign fmt = fmt_e'(cfg_fmt);

    sai_rx_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sdata_in, fclk_in, bclk_in}),
        .q     (sync_q)
    );

    // Delayed copy of both synchronised clocks for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_d <= '0;
        else        clk_d <= sync_q[1:0];
    end

    assign bclk_rise = sync_q[0] & ~clk_d[0];
    assign frm_rise  = sync_q[1] & ~clk_d[1];
    assign tick      = cfg_bclk_gen ? gen_tick : bclk_rise;

    sai_rx_bitgen #(
        .PER_W        (PER_W),
        .STEREO_SHIFT (STEREO_SHIFT),
        .TDM_SHIFT    (TDM_SHIFT)
    ) u_bitgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_bclk_gen),
        .tdm      (fmt == FMT_TDM),
        .frm_rise (frm_rise),
        .tick     (gen_tick),
        .bclk_out (bclk_out)
    );

    sai_rx_deser #(
        .LANES     (LANES),
        .SAMPLE_W  (SAMPLE_W),
        .SLOT_W    (SLOT_W),
        .TDM_SLOTS (TDM_SLOTS)
    ) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .fs          (sync_q[1]),
        .sd          (sync_q[SYNC_W-1:2]),
        .fmt         (fmt),
        .samples     (samples_out),
        .frame_valid (frame_valid)
    );
endmodule

// File: tb/sai_rx_port_tb.sv
module sai_rx_port_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cfg_fmt = 2'b00;
    logic         cfg_bclk_gen = 1'b0;
    logic         bclk_in = 1'b0;
    logic         fclk_in = 1'b0;
    logic [5:0]   sdata_in = '0;
    logic         bclk_out;
    logic [287:0] samples_out;
    logic         frame_valid;

    int n_chk = 0, n_fail = 0;
    int valid_cnt = 0, pulse_err = 0, rises = 0, cyc = 0;
    logic valid_prev = 1'b0, bclk_prev = 1'b0;
    logic [287:0] cap_samples = '0;

    always #10 clk = ~clk;

    sai_rx_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_bclk_gen(cfg_bclk_gen),
        .bclk_in(bclk_in), .fclk_in(fclk_in), .sdata_in(sdata_in),
        .bclk_out(bclk_out), .samples_out(samples_out), .frame_valid(frame_valid)
    );

    // Monitor valid pulses and generated clock edges away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (frame_valid) begin
            valid_cnt = valid_cnt + 1;
            cap_samples = samples_out;
            if (valid_prev) pulse_err = pulse_err + 1;
        end
        valid_prev = frame_valid;
        if (bclk_out && !bclk_prev) rises = rises + 1;
        bclk_prev = bclk_out;
        if (cyc == 180000) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [23:0] word_of(input int seed, input int ch);
        return 24'((seed * 32'h1F3A5) ^ (ch * 32'h0B1C7) ^ 32'h800001 ^ (ch << 20));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] fmt, input logic gen);
        @(negedge clk);
        rst_n = 1'b0; cfg_fmt = fmt; cfg_bclk_gen = gen;
        bclk_in = 1'b0; fclk_in = 1'b0; sdata_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_bit(input logic fc, input logic [5:0] d);
        fclk_in = fc; sdata_in = d;
        if (!cfg_bclk_gen) begin
            bclk_in = 1'b0;
            repeat (4) @(negedge clk);
            bclk_in = 1'b1;
            repeat (4) @(negedge clk);
        end else begin
            repeat (8) begin
                @(negedge clk);
                bclk_in = ~bclk_in;
            end
        end
    endtask

    task automatic send_stereo(input logic [1:0] fmt, input int seed, input int rbits);
        logic lvl = (fmt == 2'b00) ? 1'b0 : 1'b1;
        int   msb = (fmt == 2'b00) ? 1 : ((fmt == 2'b10) ? 8 : 0);
        for (int h = 0; h < 2; h++) begin
            int nb = h ? rbits : 32;
            for (int p = 0; p < nb; p++) begin
                logic [5:0] d = '0;
                for (int l = 0; l < 6; l++)
                    if (p >= msb && p < msb + 24) d[l] = word_of(seed, 2*l + h)[23 - (p - msb)];
                put_bit(h ? ~lvl : lvl, d);
            end
        end
    endtask

    task automatic send_tdm(input int seed, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            logic [5:0] d;
            int slot = i / 32;
            int b = i % 32;
            d[5:1] = 5'(i * 7 + 3);
            d[0] = (slot < 12 && b < 24) ? word_of(seed, slot)[23 - b] : 1'b0;
            put_bit(i == 0, d);
        end
    endtask

    task automatic idle();
        repeat (24) @(negedge clk);
    endtask

    task automatic check_frame(input int seed, input string req);
        for (int c = 0; c < 12; c++)
            chk(cap_samples[c*24 +: 24] === word_of(seed, c), req,
                32'(cap_samples[c*24 +: 24]), 32'(word_of(seed, c)));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(frame_valid === 1'b0, "R1 valid", 32'(frame_valid), 0);
        chk(samples_out === '0, "R1 samples", samples_out[31:0], 0);
        chk(bclk_out === 1'b0, "R1 bclk_out", 32'(bclk_out), 0);
    endtask

    task automatic t_stereo_slave(input logic [1:0] fmt, input string req);
        int v0, r0;
        do_reset(fmt, 1'b0);
        chk(samples_out === '0 && frame_valid === 1'b0, "R1 after release", samples_out[31:0], 0);
        for (int k = 0; k < 4; k++) put_bit((fmt == 2'b00) ? 1'b1 : 1'b0, 6'h0);
        v0 = valid_cnt; r0 = rises;
        send_stereo(fmt, 11, 32);
        send_stereo(fmt, 12, 32);
        idle();
        chk(valid_cnt - v0 == 2, req, 32'(valid_cnt - v0), 2);
        check_frame(12, req);
        chk(rises == r0, "R10 slave bclk_out", 32'(rises - r0), 0);
    endtask

    task automatic t_tdm_slave();
        int v0;
        do_reset(2'b11, 1'b0);
        v0 = valid_cnt;
        send_tdm(21, 512);
        idle();
        chk(valid_cnt - v0 == 1, "R5 count", 32'(valid_cnt - v0), 1);
        check_frame(21, "R5");
    endtask

    task automatic t_short_stereo();
        int v0;
        do_reset(2'b01, 1'b0);
        send_stereo(2'b01, 31, 32);
        idle();
        v0 = valid_cnt;
        send_stereo(2'b01, 32, 20);
        idle();
        chk(valid_cnt == v0, "R7 short pulse", 32'(valid_cnt - v0), 0);
        chk(samples_out[23:0] === word_of(31, 0), "R7 held", 32'(samples_out[23:0]), 32'(word_of(31, 0)));
        send_stereo(2'b01, 33, 32);
        idle();
        chk(valid_cnt - v0 == 1, "R7 recover", 32'(valid_cnt - v0), 1);
        check_frame(33, "R7");
    endtask

    task automatic t_short_tdm();
        int v0;
        do_reset(2'b11, 1'b0);
        send_tdm(41, 512);
        idle();
        v0 = valid_cnt;
        send_tdm(42, 300);
        send_tdm(43, 512);
        idle();
        chk(valid_cnt - v0 == 1, "R7 tdm count", 32'(valid_cnt - v0), 1);
        check_frame(43, "R7 tdm");
    endtask

    task automatic t_gen(input logic [1:0] fmt, input int nb, input string req);
        int v0, r0, n;
        do_reset(fmt, 1'b1);
        v0 = valid_cnt;
        for (int f = 0; f < 2; f++)
            if (fmt == 2'b11) send_tdm(51 + f, nb); else send_stereo(fmt, 51 + f, 32);
        r0 = rises;
        if (fmt == 2'b11) send_tdm(53, nb); else send_stereo(fmt, 53, 32);
        @(negedge clk);
        n = rises - r0;
        idle();
        chk(valid_cnt - v0 == 2, req, 32'(valid_cnt - v0), 2);
        check_frame(53, req);
        chk(n >= nb - 1 && n <= nb + 1, {req, " bclk_out edges"}, 32'(n), 32'(nb));
    endtask

    initial begin
        t_reset();
        t_stereo_slave(2'b00, "R2");
        t_stereo_slave(2'b01, "R3");
        t_stereo_slave(2'b10, "R4");
        t_tdm_slave();
        t_short_stereo();
        t_short_tdm();
        t_gen(2'b01, 64, "R8");
        t_gen(2'b11, 512, "R9");
        chk(pulse_err == 0, "R6 single-cycle valid", 32'(pulse_err), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule